// File: doc/BRIEF.md
# Square-Wave Tone Generator with Per-Pin Pulse-Density Volume

This block produces a square-wave tone on four output pins. The pins are meant to feed an external weighted resistor ladder, where pin 3 carries the largest weight and pin 0 the smallest. The pitch comes from a phase accumulator. The host sets a phase step, and the most significant accumulator bit is the tone. A note runs for a whole number of milliseconds, set by the host. A prescaler built from the clock-frequency parameter counts those milliseconds.

Volume is set per pin. Each pin has its own 4-bit level that drives an accumulate-and-carry pulse-density modulator. A pin can only be high while the tone bit is high and its modulator emits a pulse. Setting different densities on pins of unequal weight gives a non-linear, roughly logarithmic gain curve. The host uses the busy output to sequence notes one after another.

A small controller has two states, IDLE and PLAY. Its transitions are:
- START: from IDLE or PLAY to PLAY, on a write of a non-zero length.
- ABORT: to IDLE, on a write of a zero length.
- EXPIRE: from PLAY to IDLE, on the millisecond tick that completes the programmed length.

Top module: `tone_pdm_gen`

## Requirements
- R1: After reset, `busy_o` is 0 and all pins are 0. The phase step, the four levels and the length all reset to 0.
- R2: Writing a non-zero length clears the phase accumulator, the modulator accumulators, the prescaler and the elapsed-millisecond count. `busy_o` is 1 from the next cycle.
- R3: Writing a length of 0 sets `busy_o` to 0 from the next cycle. This holds whether or not a note is in progress.
- R4: A note started with length N stays busy for exactly N*(CLK_HZ/1000) cycles. It ends on a millisecond tick.
- R5: While busy, the accumulator adds the phase step (modulo 2^24) on every clock. The tone is accumulator bit 23. A pin is never high while the tone is low. A new phase step takes effect on the clock after it is written.
- R6: Each pin's modulator adds its 4-bit level into a 4-bit accumulator on every busy cycle. It pulses in the cycle after the addition carries out of bit 3, so a level L gives L pulses in every 16 busy cycles.
- R7: A level of 15 keeps its pin high on every busy cycle in which the tone is high.
- R8: With all four levels at 0, every pin stays low.
- R9: The level write data holds pin i's level in bits [4i+3:4i]. Each pin uses only its own field. A level write takes effect on the clock after it is written.
- R10: When a note expires, every pin is held low and the accumulators are frozen until the next START. Phase-step and level writes made while idle do not start a note.
- R11: A START during a note restarts timing from zero with the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_inc_we | input | 1 | Phase step write strobe |
| phase_inc_wdata | input | 24 | Phase step value |
| level_we | input | 1 | Level write strobe |
| level_wdata | input | 16 | Four 4-bit levels, pin i in bits [4i+3:4i] |
| note_ms_we | input | 1 | Length write strobe; a non-zero value starts a note, zero aborts |
| note_ms_wdata | input | 8 | Note length in milliseconds |
| pins_o | output | 4 | Gated ladder pins, bit 3 heaviest |
| busy_o | output | 1 | A note is in progress |

## Verification
The bench builds the block with CLK_HZ set to 8000, so one millisecond lasts only eight clocks. This keeps the longest length of 255 ms within a short run. It also makes the millisecond tick and the EXPIRE transition occur often enough to check the exact end cycle many times. Large phase steps such as 0x200000 and 0x800000 make the tone bit toggle every few cycles. This lets the modulator carry pattern and the tone gating show up together within a handful of milliseconds.

// File: rtl/tone_pkg.sv
package tone_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } note_state_e;
endpackage

// File: rtl/ms_timebase.sv
module ms_timebase #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int TICKS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int CW    = $clog2((TICKS > 1) ? TICKS : 2);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [PHASE_W-1:0] step,
    output logic               tone
);
    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc_q <= '0;
        else if (run)        acc_q <= acc_q + step;
    end

    assign tone = acc_q[PHASE_W-1];
endmodule

// File: rtl/pdm_channel.sv
module pdm_channel #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [LVL_W-1:0] level,
    output logic             pulse
);
    logic [LVL_W-1:0] pacc_q;
    logic             carry_q;
    logic [LVL_W:0]   sum;

    assign sum = {1'b0, pacc_q} + {1'b0, level};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pacc_q  <= '0;
            carry_q <= 1'b0;
        end else if (run) begin
            pacc_q  <= sum[LVL_W-1:0];
            carry_q <= sum[LVL_W];
        end
    end

    assign pulse = (&level) | carry_q;
endmodule

// File: rtl/note_ctrl.sv
module note_ctrl
    import tone_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_we,
    input  logic [DUR_W-1:0] start_len,
    input  logic             ms_tick,
    output logic             playing,
    output logic             clear
);
    note_state_e      state_q, state_d;
    logic [DUR_W-1:0] len_q;
    logic [DUR_W-1:0] ms_q;
    logic             last_ms;

    assign last_ms = ({1'b0, ms_q} + 1'b1) == {1'b0, len_q};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_we && start_len != '0) state_d = ST_PLAY;
            ST_PLAY: begin
                if (start_we)                state_d = (start_len != '0) ? ST_PLAY : ST_IDLE;
                else if (ms_tick && last_ms) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            ms_q  <= '0;
        end else if (start_we) begin
            len_q <= start_len;
            ms_q  <= '0;
        end else if (state_q == ST_PLAY && ms_tick) begin
            ms_q  <= ms_q + 1'b1;
        end
    end

    always_comb begin
        playing = (state_q == ST_PLAY);
        clear   = start_we;
    end
endmodule

// File: rtl/tone_pdm_gen.sv
module tone_pdm_gen #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int PHASE_W = 24,
    parameter int DUR_W   = 8,
    parameter int LVL_W   = 4,
    parameter int NPINS   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   phase_inc_we,
    input  logic [PHASE_W-1:0]     phase_inc_wdata,
    input  logic                   level_we,
    input  logic [NPINS*LVL_W-1:0] level_wdata,
    input  logic                   note_ms_we,
    input  logic [DUR_W-1:0]       note_ms_wdata,
    output logic [NPINS-1:0]       pins_o,
    output logic                   busy_o
);
    logic [PHASE_W-1:0]     inc_q;
    logic [NPINS*LVL_W-1:0] lvl_q;
    logic                   playing;
    logic                   clr;
    logic                   ms_tick;
    logic                   tone;
    logic [NPINS-1:0]       pulse;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
            lvl_q <= '0;
        end else begin
            if (phase_inc_we) inc_q <= phase_inc_wdata;
            if (level_we)     lvl_q <= level_wdata;
        end
    end

    note_ctrl #(.DUR_W(DUR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_we(note_ms_we), .start_len(note_ms_wdata),
        .ms_tick(ms_tick), .playing(playing), .clear(clr)
    );

    ms_timebase #(.CLK_HZ(CLK_HZ)) tb_i (
        .clk(clk), .rst_n(rst_n), .clear(clr), .run(playing), .tick(ms_tick)
    );

    phase_accum #(.PHASE_W(PHASE_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .clear(clr), .run(playing), .step(inc_q), .tone(tone)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pdm_channel #(.LVL_W(LVL_W)) pdm_i (
            .clk(clk), .rst_n(rst_n), .clear(clr), .run(playing),
            .level(lvl_q[g*LVL_W +: LVL_W]), .pulse(pulse[g])
        );
        assign pins_o[g] = playing & tone & pulse[g];
    end

    assign busy_o = playing;
endmodule

// File: rtl/tone_pdm_gen_chk.sv
module tone_pdm_gen_chk #(
    parameter int DUR_W = 8,
    parameter int LVL_W = 4,
    parameter int NPINS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   note_ms_we,
    input logic [DUR_W-1:0]       note_ms_wdata,
    input logic [NPINS-1:0]       pins_o,
    input logic                   busy_o,
    input logic [NPINS*LVL_W-1:0] lvl_q,
    input logic                   tone,
    input logic                   ms_tick
);
    logic [NPINS-1:0] full_mask;
    always_comb begin
        for (int i = 0; i < NPINS; i++) full_mask[i] = &lvl_q[i*LVL_W +: LVL_W];
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (note_ms_we && note_ms_wdata != '0) |=> busy_o);
    p_abort_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (note_ms_we && note_ms_wdata == '0) |=> !busy_o);
    p_end_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(note_ms_we)) |-> $past(ms_tick));
    p_tone_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tone |-> (pins_o == '0));
    p_full_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tone) |-> ((pins_o & full_mask) == full_mask));
    p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == '0) |-> (pins_o == '0));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pins_o == '0));
endmodule

bind tone_pdm_gen tone_pdm_gen_chk #(.DUR_W(DUR_W), .LVL_W(LVL_W), .NPINS(NPINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .note_ms_we(note_ms_we), .note_ms_wdata(note_ms_wdata),
    .pins_o(pins_o), .busy_o(busy_o), .lvl_q(lvl_q), .tone(tone), .ms_tick(ms_tick)
);

// File: tb/tone_pdm_gen_tb_top.sv
module tone_pdm_gen_tb_top;
    localparam int CLK_HZ = 8000;
    localparam int TICKS  = CLK_HZ / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_inc_we = 1'b0;
    logic [23:0] phase_inc_wdata = '0;
    logic        level_we = 1'b0;
    logic [15:0] level_wdata = '0;
    logic        note_ms_we = 1'b0;
    logic [7:0]  note_ms_wdata = '0;
    logic [3:0]  pins_o;
    logic        busy_o;

    always #5 clk = ~clk;

    tone_pdm_gen #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_inc_we(phase_inc_we), .phase_inc_wdata(phase_inc_wdata),
        .level_we(level_we), .level_wdata(level_wdata), .note_ms_we(note_ms_we),
        .note_ms_wdata(note_ms_wdata), .pins_o(pins_o), .busy_o(busy_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_acc, m_inc, m_pre, m_ms, m_dur;
    bit m_play;
    int m_lvl[4];
    int m_pacc[4];
    bit m_carry[4];

    function automatic logic [3:0] exp_pins();
        logic [3:0] p;
        for (int i = 0; i < 4; i++)
            p[i] = m_play && (m_acc >= 32'h800000) && (m_lvl[i] == 15 || m_carry[i]);
        return p;
    endfunction

    task automatic compare(string tag);
        logic [3:0] ep;
        ep = exp_pins();
        n_cmp++;
        if (busy_o !== m_play) begin
            n_bad++;
            $display("FAIL %s busy_o actual=%b expected=%b t=%0t", tag, busy_o, m_play, $time);
        end else if (pins_o !== ep) begin
            n_bad++;
            $display("FAIL %s pins_o actual=%b expected=%b t=%0t", tag, pins_o, ep, $time);
        end
    endtask

    task automatic step();
        int s;
        if (note_ms_we) begin
            m_play = (note_ms_wdata != 0);
            m_dur = note_ms_wdata; m_acc = 0; m_pre = 0; m_ms = 0;
            for (int i = 0; i < 4; i++) begin m_pacc[i] = 0; m_carry[i] = 0; end
        end else if (m_play) begin
            m_acc = (m_acc + m_inc) % 32'h1000000;
            for (int i = 0; i < 4; i++) begin
                s = m_pacc[i] + m_lvl[i];
                m_carry[i] = (s >= 16);
                m_pacc[i] = s % 16;
            end
            if (m_pre == TICKS - 1) begin
                m_pre = 0; m_ms++;
                if (m_ms == m_dur) m_play = 0;
            end else m_pre++;
        end
        if (phase_inc_we) m_inc = phase_inc_wdata;
        if (level_we) for (int i = 0; i < 4; i++) m_lvl[i] = (level_wdata >> (4 * i)) & 15;
        @(negedge clk);
        compare(cur_req);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic set_inc(logic [23:0] v);
        phase_inc_we = 1; phase_inc_wdata = v; step(); phase_inc_we = 0;
    endtask

    task automatic set_lvl(logic [15:0] v);
        level_we = 1; level_wdata = v; step(); level_we = 0;
    endtask

    task automatic set_dur(logic [7:0] v);
        note_ms_we = 1; note_ms_wdata = v; step(); note_ms_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        m_acc = 0; m_inc = 0; m_pre = 0; m_ms = 0; m_dur = 0; m_play = 0;
        for (int i = 0; i < 4; i++) begin m_lvl[i] = 0; m_pacc[i] = 0; m_carry[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur_req = "R1";
        compare("R1");
        run(4);

        // R8: silent with all levels zero
        cur_req = "R8";
        set_inc(24'h200000);
        set_dur(3);
        run(3 * TICKS + 4);

        // R7: full scale on every pin
        cur_req = "R7";
        set_lvl(16'hFFFF);
        set_dur(2);
        run(2 * TICKS + 3);

        // R6 / R9: mixed densities, each pin its own field
        cur_req = "R6";
        set_lvl(16'h1A53);
        set_dur(5);
        run(20);
        cur_req = "R9";
        set_lvl(16'h7F02);
        run(5 * TICKS);

        // R5: zero step keeps tone low; then a step toggling each cycle
        cur_req = "R5";
        set_inc(24'h000000);
        set_lvl(16'hFFFF);
        set_dur(2);
        run(8);
        set_inc(24'h800000);
        run(2 * TICKS);
        set_inc(24'h555555);
        set_dur(3);
        run(3 * TICKS + 2);

        // R4: exact note length, count busy cycles at the ports
        cur_req = "R4";
        set_inc(24'h200000);
        set_lvl(16'h9C6F);
        note_ms_we = 1; note_ms_wdata = 4; step(); note_ms_we = 0;
        cnt = 1;
        while (busy_o && cnt < 1000) begin step(); if (busy_o) cnt++; end
        n_cmp++;
        if (cnt != 4 * TICKS) begin
            n_bad++;
            $display("FAIL R4 busy cycles actual=%0d expected=%0d", cnt, 4 * TICKS);
        end

        // R10: writes while idle do not start a note, pins stay low
        cur_req = "R10";
        set_inc(24'h400000);
        set_lvl(16'hFFFF);
        run(20);

        // R3: abort mid note, and zero write while idle
        cur_req = "R3";
        set_dur(6);
        run(13);
        set_dur(0);
        run(6);
        set_dur(0);
        run(3);

        // R11 / R2: restart mid note with a new length
        cur_req = "R11";
        set_lvl(16'h3B8E);
        set_dur(5);
        run(19);
        set_dur(2);
        run(2 * TICKS + 3);
        cur_req = "R2";
        set_dur(1);
        run(TICKS + 2);

        // R4: longest length
        cur_req = "R4";
        set_inc(24'h0C0000);
        set_dur(255);
        run(255 * TICKS + 4);

        finish_run();
    end
endmodule